// File: doc/BRIEF.md
# Cache Attribute Region Decoder

This block decides, for every address the bus interface is about to drive, whether the access may be cached. For a cacheable access it also decides whether stores follow a write-through or a write-back policy. Software programs four attribute sources through a small write port. The first is one write-through window. The second and third are two independent non-cacheable windows. The fourth is a threshold above which all of memory is non-cacheable. The bus interface presents an address with a valid strobe and receives registered flags one clock later.

The windows are power-of-two sized, from 64 KB to 4 MB, and sit on a 64 KB grid. A window is matched on the address bits above its own size, so a base that is not aligned to its size is silently rounded down. Non-cacheable attributes take priority over the write-through attribute. Software must flush the data cache before it reprograms any window; the decoder does not track this.

Top module: `car_decoder`

## Requirements
- R1: After reset, rsp_valid, rsp_cacheable and rsp_write_through are 0, every window is disabled and the threshold code is 0, so any access is reported cacheable and write-back.
- R2: rsp_valid is 1 exactly in the cycle after an edge that sampled req_valid=1, and the flags in that cycle describe the address sampled at that edge.
- R3: A cacheable access that is outside the write-through window is reported with rsp_write_through=0 (write-back).
- R4: A write-through size code c in 1..7 selects a window of 64 KB << (c-1). The base register holds address bits [31:16]. An address hits when addr[31:16+c-1] equals base[15:c-1].
- R5: Base bits below the window size are ignored, so a misaligned base acts as the base rounded down to a multiple of the size.
- R6: Size code 0 disables a window, whatever its base holds.
- R7: Two non-cacheable windows use the same size encoding as R4, and a hit in either one gives rsp_cacheable=0.
- R8: Threshold code k in 1..9 makes every address >= 1 MB << (k-1) non-cacheable (rsp_cacheable=0); code 0 leaves all addresses cacheable.
- R9: Threshold codes 10..15 are reserved and behave as code 0.
- R10: Any non-cacheable hit forces rsp_write_through=0, even inside the write-through window.
- R11: Register select: 0 WT base, 1 WT size, 2 NC0 base, 3 NC0 size, 4 NC1 base, 5 NC1 size, 6 threshold. Base writes take cfg_wdata[15:0], size writes cfg_wdata[2:0], threshold writes cfg_wdata[3:0]. Select 7 changes nothing.
- R12: A configuration write applies only to accesses sampled at later edges; an access sampled at the same edge as the write uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| req_valid | input | 1 | Address valid strobe |
| req_addr | input | 32 | Byte address of the bus cycle |
| rsp_valid | output | 1 | Flags valid, one cycle after req_valid |
| rsp_cacheable | output | 1 | 1 when the access may be cached |
| rsp_write_through | output | 1 | 1 when a cacheable access uses write-through |

## Verification
The in-RTL assertions check the following on every cycle: the one-cycle valid pipeline; that a non-cacheable window or threshold hit always reaches the output as non-cacheable; that write-through never appears without cacheable; that a write-through window hit with no non-cacheable hit reaches the output as write-through; and that the threshold and spare selects update or leave the registers as they should. They cannot show whether the window arithmetic is right. The bench's scenarios cover that part. They sweep every size code at the window edges, use a misaligned base, sweep all threshold codes at their boundaries, and include a write that lands on the same edge as an access.

// File: rtl/car_pkg.sv
package car_pkg;

  parameter int ADDR_W        = 32;
  parameter int BASE_W        = 16;
  parameter int GRAN_LOG2     = ADDR_W - BASE_W;   // 64 KB grid
  parameter int SIZE_W        = 3;
  parameter int THR_W         = 4;
  parameter int SEL_W         = 3;
  parameter int NUM_NC        = 2;
  parameter int THR_BASE_LOG2 = 20;                // 1 MB first boundary
  parameter int THR_MAX_CODE  = 9;
  parameter int NC_SEL_FIRST  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_WT_BASE  = 3'd0,
    SEL_WT_SIZE  = 3'd1,
    SEL_NC0_BASE = 3'd2,
    SEL_NC0_SIZE = 3'd3,
    SEL_NC1_BASE = 3'd4,
    SEL_NC1_SIZE = 3'd5,
    SEL_THRESH   = 3'd6,
    SEL_SPARE    = 3'd7
  } cfg_sel_e;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [SIZE_W-1:0] size;
  } region_cfg_t;

  // Mask of base bits that take part in the compare for a size code.
  function automatic logic [BASE_W-1:0] region_mask(input logic [SIZE_W-1:0] code);
    logic [BASE_W-1:0] m;
    if (code == '0) m = '0;
    else            m = {BASE_W{1'b1}} << (code - SIZE_W'(1));
    return m;
  endfunction

  function automatic logic region_hit(input logic [BASE_W-1:0] addr_hi,
                                      input region_cfg_t       cfg);
    return (cfg.size != '0) &&
           (((addr_hi ^ cfg.base) & region_mask(cfg.size)) == '0);
  endfunction

  function automatic logic above_threshold(input logic [ADDR_W-1:0] addr,
                                           input logic [THR_W-1:0]  code);
    logic res;
    if (code == '0 || int'(code) > THR_MAX_CODE) res = 1'b0;
    else res = (addr >> (THR_BASE_LOG2 + int'(code) - 1)) != '0;
    return res;
  endfunction

endpackage

// File: rtl/car_regfile.sv
module car_regfile
  import car_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [SEL_W-1:0]         cfg_sel,
  input  logic [BASE_W-1:0]        cfg_wdata,
  output region_cfg_t              wt_cfg,
  output region_cfg_t [NUM_NC-1:0] nc_cfg,
  output logic [THR_W-1:0]         thr_code
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wt_cfg   <= '0;
      nc_cfg   <= '0;
      thr_code <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_WT_BASE) wt_cfg.base <= cfg_wdata;
      if (cfg_sel == SEL_WT_SIZE) wt_cfg.size <= cfg_wdata[SIZE_W-1:0];
      if (cfg_sel == SEL_THRESH)  thr_code    <= cfg_wdata[THR_W-1:0];
      for (int i = 0; i < NUM_NC; i++) begin
        if (cfg_sel == SEL_W'(NC_SEL_FIRST + 2*i))
          nc_cfg[i].base <= cfg_wdata;
        if (cfg_sel == SEL_W'(NC_SEL_FIRST + 2*i + 1))
          nc_cfg[i].size <= cfg_wdata[SIZE_W-1:0];
      end
    end
  end

  AST_THR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_THRESH) |=> (thr_code == $past(cfg_wdata[THR_W-1:0]))); // R11

  AST_SPARE_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_SPARE) |=> ($stable(thr_code) && $stable(wt_cfg) && $stable(nc_cfg))); // R11

endmodule

// File: rtl/car_region_match.sv
module car_region_match
  import car_pkg::*;
(
  input  logic [BASE_W-1:0] addr_hi,
  input  region_cfg_t       cfg,
  output logic              hit
);

  always_comb hit = region_hit(addr_hi, cfg);

endmodule

// File: rtl/car_threshold_cmp.sv
module car_threshold_cmp
  import car_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [THR_W-1:0]  code,
  output logic              above
);

  always_comb above = above_threshold(addr, code);

endmodule

// File: rtl/car_decoder.sv
module car_decoder
  import car_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [15:0]       cfg_wdata,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  output logic              rsp_valid,
  output logic              rsp_cacheable,
  output logic              rsp_write_through
);

  region_cfg_t              wt_cfg;
  region_cfg_t [NUM_NC-1:0] nc_cfg;
  logic [THR_W-1:0]         thr_code;
  logic [BASE_W-1:0]        addr_hi;
  logic                     wt_hit;
  logic [NUM_NC-1:0]        nc_hit_vec;
  logic                     thr_hit;
  logic                     any_nc;

  assign addr_hi = req_addr[ADDR_W-1:GRAN_LOG2];

  car_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .wt_cfg    (wt_cfg),
    .nc_cfg    (nc_cfg),
    .thr_code  (thr_code)
  );

  car_region_match u_wt_match (
    .addr_hi (addr_hi),
    .cfg     (wt_cfg),
    .hit     (wt_hit)
  );

  for (genvar g = 0; g < NUM_NC; g++) begin : g_nc
    car_region_match u_nc_match (
      .addr_hi (addr_hi),
      .cfg     (nc_cfg[g]),
      .hit     (nc_hit_vec[g])
    );
  end

  car_threshold_cmp u_thr (
    .addr  (req_addr),
    .code  (thr_code),
    .above (thr_hit)
  );

  assign any_nc = (|nc_hit_vec) | thr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid         <= 1'b0;
      rsp_cacheable     <= 1'b0;
      rsp_write_through <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_cacheable     <= ~any_nc;
        rsp_write_through <= ~any_nc & wt_hit;
      end
    end
  end

  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2

  AST_NC_REGION_BLOCKS_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (|nc_hit_vec)) |=> !rsp_cacheable); // R7

  AST_THR_BLOCKS_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && thr_hit) |=> !rsp_cacheable); // R8

  AST_NC_FORCES_WB_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_write_through && !rsp_cacheable)); // R10

  AST_WT_HIT_REACHES_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && wt_hit && !(|nc_hit_vec) && !thr_hit) |=> rsp_write_through); // R4

endmodule

// File: tb/tb_car_decoder.sv
module tb_car_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_cacheable, rsp_write_through;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // shadow configuration
  logic [15:0] sh_wt_b = '0;
  logic [2:0]  sh_wt_s = '0;
  logic [15:0] sh_nc_b [2];
  logic [2:0]  sh_nc_s [2];
  logic [3:0]  sh_thr = '0;

  always #5 clk = ~clk;

  car_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_cacheable(rsp_cacheable),
    .rsp_write_through(rsp_write_through)
  );

  function automatic bit in_window(input logic [31:0] a, input logic [15:0] b, input logic [2:0] s);
    longint unsigned sz, start;
    if (s == 0) return 0;
    sz    = 64'h1_0000 << (s - 1);
    start = {48'd0, b, 16'd0} & ~(sz - 1);
    return (longint'(a) >= start) && (longint'(a) < start + sz);
  endfunction

  function automatic bit over_limit(input logic [31:0] a, input logic [3:0] k);
    if (k == 0 || k > 9) return 0;
    return longint'(a) >= (64'd1 << (19 + k));
  endfunction

  function automatic bit exp_cache(input logic [31:0] a);
    return !(in_window(a, sh_nc_b[0], sh_nc_s[0]) || in_window(a, sh_nc_b[1], sh_nc_s[1]) ||
             over_limit(a, sh_thr));
  endfunction

  task automatic check(input string req, input string what, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      3'd0: sh_wt_b = d;
      3'd1: sh_wt_s = d[2:0];
      3'd2: sh_nc_b[0] = d;
      3'd3: sh_nc_s[0] = d[2:0];
      3'd4: sh_nc_b[1] = d;
      3'd5: sh_nc_s[1] = d[2:0];
      3'd6: sh_thr = d[3:0];
      default: ;
    endcase
  endtask

  // Drive one access and check {valid, cacheable, write_through} one cycle later.
  task automatic access(input string req, input logic [31:0] a);
    bit c, w;
    c = exp_cache(a);
    w = c && in_window(a, sh_wt_b, sh_wt_s);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, $sformatf("addr %h", a), {rsp_valid, rsp_cacheable, rsp_write_through}, {1'b1, c, w});
  endtask

  task automatic t_reset();
    check("R1", "reset outputs", {rsp_valid, rsp_cacheable, rsp_write_through}, 3'b000);
    access("R1", 32'hFFFF_FFF0);
    access("R1", 32'h0000_0000);
  endtask

  task automatic t_valid_pipe();
    access("R2", 32'h0001_2345);
    @(negedge clk);
    check("R2", "valid drops", {2'b00, rsp_valid}, 3'b000);
  endtask

  task automatic t_wt_sizes();
    write_reg(3'd0, 16'h0040);
    for (int c = 1; c <= 7; c++) begin
      logic [31:0] sz;
      sz = 32'h1_0000 << (c - 1);
      write_reg(3'd1, 16'(c));
      access("R4", 32'h0040_0000);
      access("R4", 32'h0040_0000 + sz - 1);
      access("R3", 32'h0040_0000 + sz);
      access("R3", 32'h003F_FFFF);
    end
  endtask

  task automatic t_misaligned();
    write_reg(3'd0, 16'h0123);
    write_reg(3'd1, 16'd3);
    access("R5", 32'h0120_0000);
    access("R5", 32'h0123_FFFF);
    access("R5", 32'h0124_0000);
  endtask

  task automatic t_disable();
    write_reg(3'd1, 16'd0);
    access("R6", 32'h0120_0000);
    access("R6", 32'h0123_0000);
  endtask

  task automatic t_nc();
    write_reg(3'd2, 16'h0200);
    write_reg(3'd3, 16'd1);
    write_reg(3'd4, 16'h0301);
    write_reg(3'd5, 16'd2);
    access("R7", 32'h0200_8000);
    access("R7", 32'h0201_0000);
    access("R7", 32'h0300_0004);
    access("R7", 32'h0301_FFFF);
    access("R7", 32'h0302_0000);
  endtask

  task automatic t_nc_over_wt();
    write_reg(3'd0, 16'h0200);
    write_reg(3'd1, 16'd4);
    access("R10", 32'h0200_0100);
    access("R10", 32'h0205_0000);
    write_reg(3'd1, 16'd0);
    write_reg(3'd3, 16'd0);
    write_reg(3'd5, 16'd0);
  endtask

  task automatic t_thresh();
    for (int k = 0; k <= 9; k++) begin
      logic [31:0] lim;
      lim = (k == 0) ? 32'h0010_0000 : (32'h1 << (19 + k));
      write_reg(3'd6, 16'(k));
      access("R8", lim);
      access("R8", lim - 1);
      access("R8", 32'hFFFF_FFFC);
    end
  endtask

  task automatic t_thresh_reserved();
    for (int k = 10; k <= 15; k++) begin
      write_reg(3'd6, 16'(k));
      access("R9", 32'hFFFF_0000);
      access("R9", 32'h1000_0000);
    end
    write_reg(3'd6, 16'd0);
  endtask

  task automatic t_spare();
    write_reg(3'd2, 16'h0500);
    write_reg(3'd3, 16'd1);
    write_reg(3'd6, 16'd5);
    write_reg(3'd7, 16'h0000);
    access("R11", 32'h0500_0000);
    access("R11", 32'h0100_0000);
    access("R11", 32'h00FF_FFFF);
    write_reg(3'd6, 16'd0);
    write_reg(3'd3, 16'd0);
  endtask

  task automatic t_same_edge();
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd5; cfg_wdata = 16'd1;
    req_valid = 1'b1; req_addr = 32'h0301_0000;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R12", "old config at write edge", {rsp_valid, rsp_cacheable, rsp_write_through}, 3'b110);
    sh_nc_s[1] = 3'd1;
    access("R12", 32'h0301_0000);
  endtask

  initial begin
    sh_nc_b[0] = '0; sh_nc_b[1] = '0; sh_nc_s[0] = '0; sh_nc_s[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_valid_pipe();
    t_wt_sizes();
    t_misaligned();
    t_disable();
    t_nc();
    t_nc_over_wt();
    t_thresh();
    t_thresh_reserved();
    t_spare();
    t_same_edge();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule